// File: doc/BRIEF.md
# Serial PLL Synthesizer Programmer

This block loads an external PLL frequency synthesizer from six configuration bytes held in a small byte-addressed nonvolatile memory. A single-cycle start request makes it read the bytes, group them into two 24-bit frames and send each frame over a three-wire serial link: data, clock and a latch strobe. After both frames are latched, a done pulse reports that the synthesizer has been loaded.

The six bytes sit at consecutive addresses 08h to 0Dh. The first three bytes form the first frame and the last three form the second. Within a frame the byte at the lowest address goes out first, and each byte goes out from bit 7 down to bit 0. A synthesizer that needs fewer than 24 bits takes its padding at the head of the frame, so its meaningful bits are the last ones shifted. The serial clock runs at the system clock divided by 2*HALF. Data changes only while the serial clock is low. The latch strobe is raised after the last bit of each frame.

Top module: `pll_loader`

## Requirements
- R1: After reset, ser_clk, ser_data, ser_latch, done and mem_rd are all low.
- R2: A transfer reads each address 08h to 0Dh exactly once, in ascending order, with mem_rd asserted for one cycle per read. Read data is taken from mem_rdata one cycle after the read is issued.
- R3: Frame 1 is {byte 08h, byte 09h, byte 0Ah} and is sent first. Bit 7 of byte 08h goes out first and bit 0 of byte 0Ah goes out last, so leading padding bits go out before the meaningful bits.
- R4: Frame 2 is {byte 0Bh, byte 0Ch, byte 0Dh}, uses the same bit order, and is sent only after the latch pulse of frame 1.
- R5: ser_data is sampled by the synthesizer on the rising edge of ser_clk and stays stable while ser_clk is high. Each high phase of ser_clk lasts HALF system cycles.
- R6: ser_latch is low while a frame is shifted. It rises after exactly 24 rising edges of ser_clk and stays high for 2*HALF system cycles. ser_clk is low for the whole pulse.
- R7: All three bytes of a frame have been read before the first ser_clk rising edge of that frame. No read is issued while ser_clk or ser_latch is high.
- R8: done is high for exactly one cycle, in the cycle after ser_latch falls at the end of frame 2.
- R9: A start request during a transfer has no effect: it causes no extra reads, frames or done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to load the synthesizer |
| mem_rd | output | 1 | Read strobe to the configuration memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_rd |
| ser_data | output | 1 | Serial data to the synthesizer |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_latch | output | 1 | Latch strobe after each 24-bit frame |
| done | output | 1 | One-cycle pulse after frame 2 is latched |

## Verification
The assertions check on every cycle that the latch strobe never overlaps a high serial clock, that data holds while the clock is high, that reads stay inside the six-byte window and never coincide with shifting, and that done is a single-cycle pulse. Only the bench scenarios can show the values that arrive in the frames, their bit order and padding placement, the exact read sequence, the clock and strobe widths, the cycle in which done appears, and that a start request during a transfer is dropped.

// File: rtl/pll_loader_pkg.sv
package pll_loader_pkg;
  typedef enum logic [1:0] {CTL_IDLE, CTL_FETCH, CTL_SHIFT} ctl_state_t;
  typedef enum logic [1:0] {SER_IDLE, SER_BITS, SER_LATCH} ser_state_t;
endpackage

// File: rtl/pll_fetch.sv
module pll_fetch #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 8,
  parameter int BYTES     = 3,
  parameter int BYTE_W    = 8,
  localparam int FRAME_W  = BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               blk,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic [FRAME_W-1:0] word,
  output logic               word_ok
);
  localparam int CNT_W = $clog2(BYTES + 1);
  localparam logic [CNT_W-1:0]  LAST = CNT_W'(BYTES - 1);
  localparam logic [ADDR_W-1:0] LO   = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI   = ADDR_W'(BASE_ADDR + 2 * BYTES - 1);

  logic             issuing, rd_q, blk_q;
  logic [CNT_W-1:0] idx, got;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing  <= 1'b0;
      rd_q     <= 1'b0;
      blk_q    <= 1'b0;
      idx      <= '0;
      got      <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      word     <= '0;
      word_ok  <= 1'b0;
    end else begin
      word_ok <= 1'b0;
      mem_rd  <= 1'b0;
      rd_q    <= mem_rd;
      if (issuing) begin
        mem_rd   <= 1'b1;
        mem_addr <= ADDR_W'(BASE_ADDR + (blk_q ? BYTES : 0) + int'(idx));
        idx      <= idx + 1'b1;
        if (idx == LAST) issuing <= 1'b0;
      end
      if (rd_q) begin
        word <= {word[FRAME_W-BYTE_W-1:0], mem_rdata};
        got  <= got + 1'b1;
        if (got == LAST) word_ok <= 1'b1;
      end
      if (go) begin
        issuing <= 1'b1;
        idx     <= '0;
        got     <= '0;
        blk_q   <= blk;
      end
    end
  end

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr >= LO && mem_addr <= HI)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    word_ok |-> $past(rd_q)); // R2
endmodule

// File: rtl/pll_serial.sv
module pll_serial
  import pll_loader_pkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int HALF    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  output logic               ser_data,
  output logic               ser_clk,
  output logic               ser_latch,
  output logic               fin
);
  localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  ser_state_t         st;
  logic [DIV_W-1:0]   div;
  logic [BIT_W-1:0]   bitn;
  logic               lph;
  logic [FRAME_W-1:0] shreg;
  logic               tick;

  assign tick = (div == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SER_IDLE;
      div       <= '0;
      bitn      <= '0;
      lph       <= 1'b0;
      shreg     <= '0;
      ser_data  <= 1'b0;
      ser_clk   <= 1'b0;
      ser_latch <= 1'b0;
      fin       <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        SER_IDLE: begin
          div <= '0;
          if (load) begin
            shreg    <= word;
            ser_data <= word[FRAME_W-1];
            bitn     <= '0;
            ser_clk  <= 1'b0;
            st       <= SER_BITS;
          end
        end
        SER_BITS: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!ser_clk) begin
              ser_clk <= 1'b1;
            end else begin
              ser_clk <= 1'b0;
              if (bitn == BIT_LAST) begin
                st        <= SER_LATCH;
                ser_latch <= 1'b1;
                ser_data  <= 1'b0;
                lph       <= 1'b0;
              end else begin
                shreg    <= shreg << 1;
                ser_data <= shreg[FRAME_W-2];
                bitn     <= bitn + 1'b1;
              end
            end
          end
        end
        SER_LATCH: begin
          div <= tick ? '0 : div + 1'b1;
          if (tick) begin
            if (!lph) begin
              lph <= 1'b1;
            end else begin
              ser_latch <= 1'b0;
              fin       <= 1'b1;
              st        <= SER_IDLE;
            end
          end
        end
        default: st <= SER_IDLE;
      endcase
    end
  end

  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    ser_latch |-> !ser_clk); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data)); // R5
  AST_LATCH_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_latch) |=> ser_latch); // R6
endmodule

// File: rtl/pll_loader.sv
module pll_loader
  import pll_loader_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 8,
  parameter int HALF      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_latch,
  output logic              done
);
  localparam int BYTES   = 3;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTES * BYTE_W;

  ctl_state_t         st;
  logic               blk, go, load, word_ok, fin;
  logic [FRAME_W-1:0] word;

  pll_fetch #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_fetch (
    .clk(clk), .rst(rst), .go(go), .blk(blk), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .word(word), .word_ok(word_ok)
  );

  pll_serial #(.FRAME_W(FRAME_W), .HALF(HALF)) u_serial (
    .clk(clk), .rst(rst), .load(load), .word(word), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_latch(ser_latch), .fin(fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= CTL_IDLE;
      blk  <= 1'b0;
      go   <= 1'b0;
      load <= 1'b0;
      done <= 1'b0;
    end else begin
      go   <= 1'b0;
      load <= 1'b0;
      done <= 1'b0;
      case (st)
        CTL_IDLE: if (start) begin
          blk <= 1'b0;
          go  <= 1'b1;
          st  <= CTL_FETCH;
        end
        CTL_FETCH: if (word_ok) begin
          load <= 1'b1;
          st   <= CTL_SHIFT;
        end
        CTL_SHIFT: if (fin) begin
          if (!blk) begin
            blk <= 1'b1;
            go  <= 1'b1;
            st  <= CTL_FETCH;
          end else begin
            done <= 1'b1;
            st   <= CTL_IDLE;
          end
        end
        default: st <= CTL_IDLE;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_FETCH_QUIET: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (!ser_clk && !ser_latch)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (start && st != CTL_IDLE) |=> !(go && !blk)); // R9
endmodule

// File: tb/tb_pll_loader.sv
module tb_pll_loader;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       mem_rd;
  logic [7:0] mem_addr;
  logic [7:0] mem_rdata = 8'h00;
  logic       ser_data, ser_clk, ser_latch, done;

  always #5 clk = ~clk;

  pll_loader #(.ADDR_W(8), .BASE_ADDR(8), .HALF(HALF)) dut (
    .clk(clk), .rst(rst), .start(start), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .done(done)
  );

  logic [7:0] mem [0:15];
  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural receiver model, evaluated every clock at the falling edge
  bit         p_clk, p_latch, p_data, p_done;
  int         hi_len, le_len, nbits, frames, dones, since_fall;
  logic [23:0] acc;
  logic [7:0] rd_log [$];
  logic [23:0] frame_log [$];

  always @(negedge clk) begin
    if (rst) begin
      chk(!ser_clk && !ser_latch && !ser_data && !done && !mem_rd, "R1", "outputs in reset",
          {ser_clk, ser_latch, ser_data, done, mem_rd}, 0);
      p_clk = 0; p_latch = 0; p_data = 0; p_done = 0;
      hi_len = 0; le_len = 0; nbits = 0; since_fall = 100;
    end else begin
      since_fall++;
      if (mem_rd) begin
        rd_log.push_back(mem_addr);
        if (ser_clk || ser_latch) chk(0, "R7", "read during shifting", 1, 0);
      end
      if (ser_clk && !p_clk) begin
        if (nbits == 0)
          chk(rd_log.size() == 3 * (frames + 1), "R7", "reads before first bit",
              rd_log.size(), 3 * (frames + 1));
        acc = {acc[22:0], ser_data};
        nbits++;
      end
      if (ser_clk && p_clk && ser_data != p_data) chk(0, "R5", "data moved while clock high", ser_data, p_data);
      if (ser_clk) hi_len++;
      if (!ser_clk && p_clk) begin
        if (hi_len != HALF) chk(0, "R5", "clock high width", hi_len, HALF);
        hi_len = 0;
      end
      if (ser_latch && ser_clk) chk(0, "R6", "clock high during latch", 1, 0);
      if (ser_latch) le_len++;
      if (ser_latch && !p_latch) begin
        chk(nbits == 24, "R6", "bits before latch", nbits, 24);
        frame_log.push_back(acc);
        frames++;
        nbits = 0;
      end
      if (!ser_latch && p_latch) begin
        chk(le_len == 2 * HALF, "R6", "latch width", le_len, 2 * HALF);
        le_len = 0;
        since_fall = 0;
      end
      if (done) begin
        dones++;
        chk(!p_done, "R8", "done width", 1, 0);
        chk(since_fall == 1, "R8", "done delay after latch fall", since_fall, 1);
        chk(frames % 2 == 0 && frames > 0, "R8", "done after frame 2", frames, 2);
      end
      p_clk = ser_clk; p_latch = ser_latch; p_data = ser_data; p_done = done;
    end
  end

  task automatic load_mem(input logic [7:0] b0, b1, b2, b3, b4, b5);
    mem[8] = b0; mem[9] = b1; mem[10] = b2; mem[11] = b3; mem[12] = b4; mem[13] = b5;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_xfer(input string name, input int busy_start_at);
    int rd0, fr0, dn0, n;
    rd0 = rd_log.size(); fr0 = frames; dn0 = dones;
    pulse_start();
    if (busy_start_at > 0) begin
      repeat (busy_start_at) @(posedge clk);
      pulse_start();
    end
    n = 0;
    while (dones == dn0 && n < 2000) begin @(posedge clk); n++; end
    repeat (300) @(posedge clk);
    chk(rd_log.size() - rd0 == 6, "R2", {name, " read count"}, rd_log.size() - rd0, 6);
    for (int i = 0; i < 6; i++)
      if (rd0 + i < rd_log.size())
        chk(rd_log[rd0 + i] == 8'(8 + i), "R2", {name, " read order"}, rd_log[rd0 + i], 8 + i);
    chk(frames - fr0 == 2, "R9", {name, " frame count"}, frames - fr0, 2);
    chk(dones - dn0 == 1, "R9", {name, " done count"}, dones - dn0, 1);
    if (frames - fr0 >= 2) begin
      chk(frame_log[fr0] == {mem[8], mem[9], mem[10]}, "R3", {name, " frame 1"},
          frame_log[fr0], {mem[8], mem[9], mem[10]});
      chk(frame_log[fr0 + 1] == {mem[11], mem[12], mem[13]}, "R4", {name, " frame 2"},
          frame_log[fr0 + 1], {mem[11], mem[12], mem[13]});
    end
  endtask

  initial begin
    frames = 0; dones = 0; acc = '0;
    for (int i = 0; i < 16; i++) mem[i] = 8'(8'hE0 + i);
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    repeat (20) @(posedge clk);
    #2 chk(!mem_rd && !ser_clk && !ser_latch && !done, "R1", "idle without start", mem_rd, 0);
    load_mem(8'hA5, 8'h3C, 8'h81, 8'h5A, 8'hC3, 8'h18);
    run_xfer("pattern A", 0);
    load_mem(8'h00, 8'h0F, 8'hA5, 8'h00, 8'h01, 8'hFF);   // leading padding zeros
    run_xfer("padded R3", 0);
    load_mem(8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00);
    run_xfer("ones then zeros R4", 0);
    load_mem(8'h12, 8'h34, 8'h56, 8'h9A, 8'hBC, 8'hDE);
    run_xfer("start while busy R9", 40);
    load_mem(8'h6B, 8'hD2, 8'h0E, 8'h71, 8'h4C, 8'hB9);
    run_xfer("start late in frame 2 R9", 150);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule